// File: doc/BRIEF.md
# DMA Channel Bytecode Interpreter

This block runs one DMA channel thread written as a byte-coded program. The program sits in a small external program memory. The block reads that memory through a combinational byte port addressed by its program counter. It consumes one program byte per clock and decodes instructions of one, two or six bytes. It holds three working registers: a source address, a destination address and a channel control word. Two 8-bit hardware loop counters allow one level of nesting inside another.

A load instruction issues a one-cycle read request and a store instruction issues a one-cycle write request. Every request carries the matching address and the control word. The memory side answers each request with a one-cycle acknowledge; acknowledges may arrive much later and in any number of cycles. The thread can raise a numbered event pulse. It wait on barrier instructions until every request in flight has been answered. It stops on an end instruction. On an opcode it does not know, it stops and records a fault.

Top module: `dmaByteEngine`

## Requirements
- R1: After reset the thread is idle (`busy` low), `fault` is low, `memReqValid` and `evtValid` are low, and `progAddr` is 0.
- R2: While idle, a cycle with `startValid` high loads `progAddr` from `startAddr`, clears `fault` and raises `busy` from the next cycle. While busy, `startValid` is ignored. While idle with no start, `progAddr` holds.
- R3: One program byte is consumed per cycle. Opcode 0x00 (end) lowers `busy` in the next cycle, and `progAddr` keeps the address of that end byte.
- R4: Opcode 0x04 makes `memReqValid` high for exactly the next cycle, with `memReqWrite`=0, `memReqAddr`=source register and `memReqCtrl`=control register. Opcode 0x08 does the same with `memReqWrite`=1 and the destination register.
- R5: Opcode 0xBC is followed by a selector byte and then four immediate bytes, least significant first. Selector low bits 0 write the source register, 1 the control register and 2 the destination register. Any other selector writes nothing.
- R6: Opcodes 0x20 and 0x22 load loop counter 0 (bit 1 clear) or counter 1 (bit 1 set) from the following byte, which holds the iteration count minus one.
- R7: Opcodes 0x38 and 0x3C end a loop on counter 0 (bit 2 clear) or counter 1 (bit 2 set). The next byte is the distance back from the loop-end opcode to the body start. A nonzero counter is decremented and execution jumps to (loop-end address − distance). A zero counter falls through to the byte after the instruction, so a body runs count times.
- R8: The two counters nest: an outer loop of A iterations around an inner loop of B iterations runs the inner body A×B times.
- R9: Opcode 0x34 followed by byte E makes `evtValid` high for exactly one cycle with `evtNum` = E[7:3]. It issues no memory request in that cycle.
- R10: Opcode 0x18 does nothing for one byte. Opcodes 0x12 and 0x13 hold `progAddr` until no request is waiting for an acknowledge.
- R11: At most MAX_OUTSTANDING requests (default 4) are unacknowledged at any time. A load or store stalls while the limit is reached.
- R12: Any other opcode byte, including the loop-end form 0x28, raises `fault`, latches its address on `faultPc` and returns the thread to idle. `fault` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startValid | input | 1 | Start request, accepted only while idle |
| startAddr | input | 32 | Entry address of the program |
| progAddr | output | 32 | Program counter, byte address into program memory |
| progData | input | 8 | Program byte at `progAddr`, combinational |
| memReqValid | output | 1 | One-cycle memory request strobe |
| memReqWrite | output | 1 | 1 for store (write), 0 for load (read) |
| memReqAddr | output | 32 | Request address |
| memReqCtrl | output | 32 | Channel control word sent with the request |
| memAck | input | 1 | One acknowledge per earlier request |
| evtValid | output | 1 | Event pulse |
| evtNum | output | 5 | Event number |
| busy | output | 1 | Thread is executing |
| fault | output | 1 | Thread stopped on an unknown opcode |
| faultPc | output | 32 | Address of the faulting opcode |

## Verification
The checks assume that the memory side acknowledges only requests already issued, at most one per cycle. They also assume that `progData` always shows the byte at the current `progAddr`. The bench keeps to this by answering each request from a queue of due cycles that are strictly increasing, never earlier than the cycle after the request. It serves program bytes from its own byte array indexed by `progAddr`. A slow acknowledge mode holds requests in flight long enough to reach the outstanding limit. This lets the stall and barrier paths run under nested loops.

// File: rtl/dmaBytePkg.sv
package dmaBytePkg;
  localparam logic [7:0] OP_END   = 8'h00;
  localparam logic [7:0] OP_LOAD  = 8'h04;
  localparam logic [7:0] OP_STORE = 8'h08;
  localparam logic [7:0] OP_RBAR  = 8'h12;
  localparam logic [7:0] OP_WBAR  = 8'h13;
  localparam logic [7:0] OP_NOP   = 8'h18;
  localparam logic [7:0] OP_LOOP0 = 8'h20;
  localparam logic [7:0] OP_LOOP1 = 8'h22;
  localparam logic [7:0] OP_EVENT = 8'h34;
  localparam logic [7:0] OP_LEND0 = 8'h38;
  localparam logic [7:0] OP_LEND1 = 8'h3C;
  localparam logic [7:0] OP_MOVE  = 8'hBC;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ARGS} engState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic loadPc;
    logic pcInc;
    logic pcBranch;
    logic latchSel;
    logic shiftImm;
    logic writeReg;
    logic loadCnt;
    logic decCnt;
    logic cntSel;
    logic issueLoad;
    logic issueStore;
    logic fireEvent;
    logic setFault;
    logic clrFault;
  } engStrobe_t;
endpackage

// File: rtl/dmaByteCtrl.sv
module dmaByteCtrl
  import dmaBytePkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startValid,
  input  logic [7:0] progData,
  input  logic [1:0] cntZero,
  input  logic       outZero,
  input  logic       outFull,
  output engStrobe_t strobe,
  output logic       busy
);
  localparam int MOVE_ARGS = ADDR_W / 8 + 1;
  localparam int ARG_W     = $clog2(MOVE_ARGS + 1);

  engState_t        state, nextState;
  logic [7:0]       opReg, nextOp;
  logic [ARG_W-1:0] argLeft, nextArg;
  logic             lastArg;

  assign lastArg = (argLeft == ARG_W'(1));

  always_comb begin
    strobe    = '0;
    nextState = state;
    nextOp    = opReg;
    nextArg   = argLeft;
    case (state)
      ST_IDLE: begin
        if (startValid) begin
          strobe.loadPc   = 1'b1;
          strobe.clrFault = 1'b1;
          nextState       = ST_RUN;
        end
      end
      ST_RUN: begin
        case (progData)
          OP_END:  nextState = ST_IDLE;
          OP_LOAD: begin
            if (!outFull) begin
              strobe.issueLoad = 1'b1;
              strobe.pcInc     = 1'b1;
            end
          end
          OP_STORE: begin
            if (!outFull) begin
              strobe.issueStore = 1'b1;
              strobe.pcInc      = 1'b1;
            end
          end
          OP_NOP:  strobe.pcInc = 1'b1;
          OP_RBAR, OP_WBAR: strobe.pcInc = outZero;
          OP_MOVE: begin
            strobe.pcInc = 1'b1;
            nextOp       = progData;
            nextArg      = ARG_W'(MOVE_ARGS);
            nextState    = ST_ARGS;
          end
          OP_LOOP0, OP_LOOP1, OP_LEND0, OP_LEND1, OP_EVENT: begin
            strobe.pcInc = 1'b1;
            nextOp       = progData;
            nextArg      = ARG_W'(1);
            nextState    = ST_ARGS;
          end
          default: begin
            strobe.setFault = 1'b1;
            nextState       = ST_IDLE;
          end
        endcase
      end
      default: begin
        nextArg = argLeft - ARG_W'(1);
        if (lastArg) nextState = ST_RUN;
        case (opReg)
          OP_MOVE: begin
            strobe.pcInc    = 1'b1;
            strobe.latchSel = (argLeft == ARG_W'(MOVE_ARGS));
            strobe.shiftImm = (argLeft != ARG_W'(MOVE_ARGS));
            strobe.writeReg = lastArg;
          end
          OP_LOOP0, OP_LOOP1: begin
            strobe.pcInc   = 1'b1;
            strobe.loadCnt = 1'b1;
            strobe.cntSel  = opReg[1];
          end
          OP_LEND0, OP_LEND1: begin
            strobe.cntSel = opReg[2];
            if (cntZero[opReg[2]]) strobe.pcInc = 1'b1;
            else begin
              strobe.pcBranch = 1'b1;
              strobe.decCnt   = 1'b1;
            end
          end
          OP_EVENT: begin
            strobe.pcInc     = 1'b1;
            strobe.fireEvent = 1'b1;
          end
          default: strobe.pcInc = 1'b1;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      opReg   <= OP_END;
      argLeft <= '0;
    end else begin
      state   <= nextState;
      opReg   <= nextOp;
      argLeft <= nextArg;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/dmaByteDatapath.sv
module dmaByteDatapath
  import dmaBytePkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LOOP_W          = 8,
  parameter int NUM_LOOPS       = 2,
  parameter int MAX_OUTSTANDING = 4,
  parameter int EVT_W           = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  engStrobe_t        strobe,
  input  logic [7:0]        progData,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              memAck,
  output logic [ADDR_W-1:0] progAddr,
  output logic [1:0]        cntZero,
  output logic              outZero,
  output logic              outFull,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] memReqCtrl,
  output logic              evtValid,
  output logic [EVT_W-1:0]  evtNum,
  output logic              fault,
  output logic [ADDR_W-1:0] faultPc
);
  localparam int OUT_W = $clog2(MAX_OUTSTANDING + 1);

  logic [ADDR_W-1:0] pcReg, srcReg, dstReg, ctlReg, immReg, immNext;
  logic [2:0]        selReg;
  logic [OUT_W-1:0]  outCnt;
  logic              issue;

  assign immNext = {progData, immReg[ADDR_W-1:8]};
  assign issue   = strobe.issueLoad | strobe.issueStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcReg <= '0;
    end else if (strobe.loadPc) begin
      pcReg <= startAddr;
    end else if (strobe.pcBranch) begin
      pcReg <= pcReg - ADDR_W'(1) - ADDR_W'(progData);
    end else if (strobe.pcInc) begin
      pcReg <= pcReg + ADDR_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcReg <= '0;
      dstReg <= '0;
      ctlReg <= '0;
      immReg <= '0;
      selReg <= '0;
    end else begin
      if (strobe.latchSel) selReg <= progData[2:0];
      if (strobe.shiftImm) immReg <= immNext;
      if (strobe.writeReg) begin
        case (selReg)
          3'd0:    srcReg <= immNext;
          3'd1:    ctlReg <= immNext;
          3'd2:    dstReg <= immNext;
          default: ;
        endcase
      end
    end
  end

  // one counter per loop level
  for (genvar g = 0; g < NUM_LOOPS; g++) begin : gLoop
    logic [LOOP_W-1:0] cnt;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cnt <= '0;
      else if (strobe.cntSel == 1'(g)) begin
        if (strobe.loadCnt)     cnt <= progData[LOOP_W-1:0];
        else if (strobe.decCnt) cnt <= cnt - LOOP_W'(1);
      end
    end
    assign cntZero[g] = (cnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) outCnt <= '0;
    else outCnt <= outCnt + OUT_W'(issue) - OUT_W'(memAck);
  end
  assign outZero = (outCnt == '0);
  assign outFull = (outCnt == OUT_W'(MAX_OUTSTANDING));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memReqValid <= 1'b0;
      memReqWrite <= 1'b0;
      memReqAddr  <= '0;
      memReqCtrl  <= '0;
      evtValid    <= 1'b0;
      evtNum      <= '0;
      fault       <= 1'b0;
      faultPc     <= '0;
    end else begin
      memReqValid <= issue;
      evtValid    <= strobe.fireEvent;
      if (issue) begin
        memReqWrite <= strobe.issueStore;
        memReqAddr  <= strobe.issueStore ? dstReg : srcReg;
        memReqCtrl  <= ctlReg;
      end
      if (strobe.fireEvent) evtNum <= progData[7:8-EVT_W];
      if (strobe.setFault) begin
        fault   <= 1'b1;
        faultPc <= pcReg;
      end else if (strobe.clrFault) begin
        fault <= 1'b0;
      end
    end
  end

  assign progAddr = pcReg;
endmodule

// File: rtl/dmaByteEngine.sv
module dmaByteEngine
  import dmaBytePkg::*;
#(
  parameter int ADDR_W          = 32,
  parameter int LOOP_W          = 8,
  parameter int MAX_OUTSTANDING = 4,
  parameter int EVT_W           = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startValid,
  input  logic [ADDR_W-1:0] startAddr,
  output logic [ADDR_W-1:0] progAddr,
  input  logic [7:0]        progData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] memReqCtrl,
  input  logic              memAck,
  output logic              evtValid,
  output logic [EVT_W-1:0]  evtNum,
  output logic              busy,
  output logic              fault,
  output logic [ADDR_W-1:0] faultPc
);
  engStrobe_t strobe;
  logic [1:0] cntZero;
  logic       outZero, outFull;

  dmaByteCtrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .progData(progData),
    .cntZero(cntZero), .outZero(outZero), .outFull(outFull),
    .strobe(strobe), .busy(busy)
  );

  dmaByteDatapath #(
    .ADDR_W(ADDR_W), .LOOP_W(LOOP_W), .NUM_LOOPS(2),
    .MAX_OUTSTANDING(MAX_OUTSTANDING), .EVT_W(EVT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .progData(progData),
    .startAddr(startAddr), .memAck(memAck), .progAddr(progAddr),
    .cntZero(cntZero), .outZero(outZero), .outFull(outFull),
    .memReqValid(memReqValid), .memReqWrite(memReqWrite),
    .memReqAddr(memReqAddr), .memReqCtrl(memReqCtrl),
    .evtValid(evtValid), .evtNum(evtNum), .fault(fault), .faultPc(faultPc)
  );
endmodule

// File: rtl/dmaByteChecker.sv
module dmaByteChecker #(
  parameter int ADDR_W          = 32,
  parameter int MAX_OUTSTANDING = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] progAddr,
  input logic              memReqValid,
  input logic              memAck,
  input logic              evtValid,
  input logic              busy,
  input logic              fault
);
  logic [7:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else inFlight <= inFlight + 8'(memReqValid) - 8'(memAck);
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= 8'(MAX_OUTSTANDING));

  assert_req_from_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> $past(busy));

  assert_event_alone_R9: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (!memReqValid && $past(busy)));

  assert_fault_halts_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> !busy);

  assert_idle_pc_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && $past(!busy)) |-> $stable(progAddr));

  // input assumption: every acknowledge answers an earlier request (R10)
  assert_ack_matched_R10: assert property (@(posedge clk) disable iff (!rstN)
    memAck |-> (inFlight != 8'd0 || memReqValid));
endmodule

bind dmaByteEngine dmaByteChecker #(
  .ADDR_W(ADDR_W), .MAX_OUTSTANDING(MAX_OUTSTANDING)
) chk_i (
  .clk(clk), .rstN(rstN), .progAddr(progAddr), .memReqValid(memReqValid),
  .memAck(memAck), .evtValid(evtValid), .busy(busy), .fault(fault)
);

// File: tb/dmaByteEngine_tb_top.sv
module dmaByteEngine_tb_top;
  localparam int MAXO = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [31:0] startAddr = '0;
  logic [31:0] progAddr;
  logic [7:0]  progData;
  logic        memReqValid, memReqWrite, memAck = 1'b0;
  logic [31:0] memReqAddr, memReqCtrl;
  logic        evtValid, busy, fault;
  logic [4:0]  evtNum;
  logic [31:0] faultPc;

  logic [7:0] mem [256];
  assign progData = mem[progAddr[7:0]];

  always #4 clk = ~clk;

  dmaByteEngine dut_i (
    .clk(clk), .rstN(rstN), .startValid(startValid), .startAddr(startAddr),
    .progAddr(progAddr), .progData(progData), .memReqValid(memReqValid),
    .memReqWrite(memReqWrite), .memReqAddr(memReqAddr), .memReqCtrl(memReqCtrl),
    .memAck(memAck), .evtValid(evtValid), .evtNum(evtNum), .busy(busy),
    .fault(fault), .faultPc(faultPc)
  );

  int checks = 0, errors = 0, cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model, stepped on every rising edge ----------
  int          mSt = 0, mLeft = 0, mOp = 0, mSel = 0, mOut = 0;
  int          mCnt [2] = '{0, 0};
  logic [31:0] mPc = 0, mSrc = 0, mDst = 0, mCtl = 0, mImm = 0, mFpc = 0;
  bit          mFault = 0, eReqV = 0, eReqW = 0, eEvV = 0;
  logic [31:0] eReqA = 0, eReqC = 0;
  int          eEvN = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mLeft = 0; mOp = 0; mSel = 0; mOut = 0; mCnt = '{0, 0};
      mPc = 0; mSrc = 0; mDst = 0; mCtl = 0; mImm = 0; mFpc = 0; mFault = 0;
      eReqV = 0; eEvV = 0;
    end else begin
      int b;
      b = int'(mem[mPc[7:0]]);
      eReqV = 0; eEvV = 0;
      if (mSt == 0) begin
        if (startValid) begin mPc = startAddr; mFault = 0; mSt = 1; end
      end else if (mSt == 1) begin
        if (b == 0) mSt = 0;
        else if (b == 4 || b == 8) begin
          if (mOut < MAXO) begin
            eReqV = 1; eReqW = (b == 8); eReqA = (b == 8) ? mDst : mSrc;
            eReqC = mCtl; mPc++;
          end
        end else if (b == 'h18) mPc++;
        else if (b == 'h12 || b == 'h13) begin
          if (mOut == 0) mPc++;
        end else if (b == 'hBC) begin mOp = b; mLeft = 5; mSt = 2; mPc++; end
        else if (b == 'h20 || b == 'h22 || b == 'h38 || b == 'h3C || b == 'h34) begin
          mOp = b; mLeft = 1; mSt = 2; mPc++;
        end else begin mFault = 1; mFpc = mPc; mSt = 0; end
      end else begin
        if (mOp == 'hBC) begin
          if (mLeft == 5) mSel = b % 8;
          else mImm = {b[7:0], mImm[31:8]};
          if (mLeft == 1) begin
            if (mSel == 0) mSrc = mImm;
            else if (mSel == 1) mCtl = mImm;
            else if (mSel == 2) mDst = mImm;
          end
          mPc++;
        end else if (mOp == 'h20 || mOp == 'h22) begin
          mCnt[(mOp / 2) % 2] = b; mPc++;
        end else if (mOp == 'h38 || mOp == 'h3C) begin
          int k;
          k = (mOp / 4) % 2;
          if (mCnt[k] != 0) begin mCnt[k]--; mPc = mPc - 1 - b; end
          else mPc++;
        end else begin
          eEvV = 1; eEvN = b / 8; mPc++;
        end
        mLeft--;
        if (mLeft == 0) mSt = 1;
      end
      mOut = mOut + int'(eReqV) - int'(memAck);
    end
  end

  // ---------------- per-cycle compare and acknowledge driver ---------------
  int dueQ[$];
  int lastDue = 0, ackDelay = 0, reqCount = 0;
  int loads = 0, stores = 0, inFlight = 0, maxInFlight = 0, lastEvt = -1;
  logic [31:0] loadAddrs[$];
  logic [31:0] storeAddr = 0, loadCtrl = 0;
  int wd = 0;

  always @(negedge clk) begin
    wd++;
    if (wd > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", wd);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rstN) begin
      cyc++;
      check(busy == (mSt != 0), "R3", "busy", busy, mSt != 0);
      check(progAddr == mPc, "R3", "progAddr", progAddr, mPc);
      check(memReqValid == eReqV, "R4", "memReqValid", memReqValid, eReqV);
      if (memReqValid && eReqV) begin
        check(memReqWrite == eReqW, "R4", "memReqWrite", memReqWrite, eReqW);
        check(memReqAddr == eReqA, "R4", "memReqAddr", memReqAddr, eReqA);
        check(memReqCtrl == eReqC, "R4", "memReqCtrl", memReqCtrl, eReqC);
      end
      check(evtValid == eEvV, "R9", "evtValid", evtValid, eEvV);
      if (evtValid && eEvV) check(evtNum == eEvN, "R9", "evtNum", evtNum, eEvN);
      check(fault == mFault, "R12", "fault", fault, mFault);
      if (fault) check(faultPc == mFpc, "R12", "faultPc", faultPc, mFpc);
      if (memReqValid) begin
        int d;
        reqCount++;
        inFlight++;
        if (memReqWrite) begin stores++; storeAddr = memReqAddr; end
        else begin loads++; loadAddrs.push_back(memReqAddr); loadCtrl = memReqCtrl; end
        d = (ackDelay > 0) ? ackDelay : 1 + (reqCount % 3);
        lastDue = (cyc + d > lastDue + 1) ? cyc + d : lastDue + 1;
        dueQ.push_back(lastDue);
      end
      if (inFlight > maxInFlight) maxInFlight = inFlight;
      if (evtValid) lastEvt = int'(evtNum);
      if (dueQ.size() > 0 && dueQ[0] <= cyc) begin
        void'(dueQ.pop_front());
        memAck = 1'b1;
        inFlight--;
      end else memAck = 1'b0;
    end
  end

  // ---------------- stimulus ------------------------------------------------
  task automatic put(input int a, input int b);
    mem[a] = 8'(b);
  endtask

  task automatic putMove(input int a, input int sel, input logic [31:0] v);
    put(a, 'hBC); put(a + 1, sel);
    put(a + 2, v[7:0]); put(a + 3, v[15:8]); put(a + 4, v[23:16]); put(a + 5, v[31:24]);
  endtask

  task automatic startProg(input logic [31:0] a);
    startValid = 1'b1; startAddr = a;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic clearSeen();
    loads = 0; stores = 0; maxInFlight = inFlight; lastEvt = -1;
    loadAddrs.delete();
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    // program A at 0x00: moves, load, store, event, nop, barrier, bad selector
    putMove('h00, 0, 32'h11223344);
    putMove('h06, 2, 32'hAABB0010);
    putMove('h0C, 1, 32'h000000C5);
    put('h12, 'h04); put('h13, 'h08);
    put('h14, 'h34); put('h15, 5 * 8);
    put('h16, 'h18); put('h17, 'h13);
    putMove('h18, 5, 32'hFFFFFFFF);
    put('h1E, 'h04); put('h1F, 'h00);
    // program B at 0x40: single loop of 5
    put('h40, 'h20); put('h41, 4);
    put('h42, 'h04); put('h43, 'h08);
    put('h44, 'h38); put('h45, 2);
    put('h46, 'h34); put('h47, 1 * 8);
    put('h48, 'h12); put('h49, 'h00);
    // program C at 0x80: 3 x 4 nested loop, then barrier
    put('h80, 'h22); put('h81, 2);
    put('h82, 'h20); put('h83, 3);
    put('h84, 'h04); put('h85, 'h08);
    put('h86, 'h38); put('h87, 2);
    put('h88, 'h3C); put('h89, 6);
    put('h8A, 'h12); put('h8B, 'h00);
    // program D at 0xC0: infinite loop-end form is unknown
    put('hC0, 'h18); put('hC1, 'h28); put('hC2, 'h00);
    // program E at 0xD0: clean; program F at 0xE0: unknown byte
    put('hD0, 'h18); put('hD1, 'h00);
    put('hE0, 'h77);

    repeat (3) @(negedge clk);
    check(busy == 0, "R1", "busy after reset", busy, 0);
    check(fault == 0, "R1", "fault after reset", fault, 0);
    check(memReqValid == 0 && evtValid == 0, "R1", "strobes after reset",
          {memReqValid, evtValid}, 0);
    check(progAddr == 0, "R1", "progAddr after reset", progAddr, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(progAddr == 0 && !busy, "R2", "idle pc hold", progAddr, 0);

    clearSeen();
    startProg(32'h0);
    check(busy == 1, "R2", "busy after start", busy, 1);
    waitIdle();
    check(progAddr == 32'h1F, "R3", "stop on end byte", progAddr, 32'h1F);
    check(loads == 2, "R4", "load count A", loads, 2);
    check(loadAddrs.size() > 0 && loadAddrs[0] == 32'h11223344, "R4", "load addr",
          loadAddrs.size() > 0 ? loadAddrs[0] : 0, 32'h11223344);
    check(storeAddr == 32'hAABB0010, "R4", "store addr", storeAddr, 32'hAABB0010);
    check(loadCtrl == 32'hC5, "R5", "control word", loadCtrl, 32'hC5);
    check(loadAddrs.size() > 1 && loadAddrs[1] == 32'h11223344, "R5",
          "bad selector writes nothing", loadAddrs.size() > 1 ? loadAddrs[1] : 0,
          32'h11223344);
    check(lastEvt == 5, "R9", "event number", lastEvt, 5);

    clearSeen();
    startProg(32'h40);
    repeat (4) @(negedge clk);
    startValid = 1'b1; startAddr = 32'hC0;
    @(negedge clk);
    startValid = 1'b0;
    waitIdle();
    check(fault == 0, "R2", "start while busy ignored", fault, 0);
    check(loads == 5, "R6", "loop count loads", loads, 5);
    check(stores == 5, "R7", "loop body stores", stores, 5);
    check(progAddr == 32'h49, "R7", "fall through", progAddr, 32'h49);
    check(lastEvt == 1, "R9", "event after loop", lastEvt, 1);
    check(inFlight == 0, "R10", "barrier drained", inFlight, 0);

    clearSeen();
    ackDelay = 12;
    startProg(32'h80);
    waitIdle();
    check(loads == 12, "R8", "nested loads", loads, 12);
    check(stores == 12, "R8", "nested stores", stores, 12);
    check(maxInFlight == MAXO, "R11", "outstanding limit reached", maxInFlight, MAXO);
    check(inFlight == 0, "R10", "barrier before end", inFlight, 0);
    ackDelay = 0;
    repeat (20) @(negedge clk);

    startProg(32'hC0);
    waitIdle();
    check(fault == 1, "R12", "fault on 0x28", fault, 1);
    check(faultPc == 32'hC1, "R12", "fault address", faultPc, 32'hC1);
    check(busy == 0, "R12", "halt on fault", busy, 0);
    startProg(32'hD0);
    check(fault == 0, "R12", "fault cleared by start", fault, 0);
    waitIdle();
    check(progAddr == 32'hD1, "R10", "nop advances one", progAddr, 32'hD1);
    startProg(32'hE0);
    waitIdle();
    check(fault == 1 && faultPc == 32'hE0, "R12", "second fault", faultPc, 32'hE0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule